// File: doc/BRIEF.md
# PCI Configuration Address/Data Bridge

This block is the host end of PCI configuration access. It decodes a 16 MB window on a simple CPU register bus. A byte-addressed request carries an address, a read/write flag, a size of 1, 2 or 4 bytes, and write data. Inside the window, one location latches a configuration address. A second location is a data port. Each access to the data port becomes one configuration cycle. The cycle goes either to one of a set of downstream device slots or to the bridge's own small configuration header.

The latched address holds four fields: a type bit, a register index, a function number and a one-hot device select in its upper bits. The bridge rejects type-1 cycles and selects that are not one-hot, and it turns accesses to absent targets into all-ones reads. The CPU side is big-endian and the configuration side is little-endian, so data is lane-reversed when it crosses between them. A downstream target sees a one-cycle strobe and returns read data with a present flag in the following cycle. Every request that hits the window is answered by a one-cycle acknowledge in the cycle after the request.

Top module: `cfg_bridge`

## Requirements
- R1: Only addresses whose bits 31:24 equal 0xF0 + 2*BRIDGE_IDX (0xF2 by default) respond. Such a request raises ack_o for exactly one cycle, one clock after req_i. Any other address produces no ack_o.
- R2: An access with address bit 23 set and bit 22 clear reaches the address latch. A write stores wdata_i with its four bytes reversed, whatever the size. A read returns the stored word unchanged. The latch is zero after reset.
- R3: An access with bits 23 and 22 both set is a data access. It drives cfg_reg_o = latch[7:2], cfg_fn_o = latch[10:8] and cfg_dev_o = (index of the single set select bit) + 11. cfg_be_o is computed from the size and address bits 1:0. Size 1 gives the single lane addr[1:0]. Size 2 gives lanes {addr[1],0} and {addr[1],1}. Size 4 gives all four lanes.
- R4: CPU byte lane j sits on bits [31-8j -: 8]. It maps to configuration lane j on bits [8j +: 8], for write data and for read data.
- R5: When latch bit 0 (the type bit) is 1, a data read returns 0xFFFFFFFF and a data write produces no downstream strobe.
- R6: The device select is latch bits 31:11. If it is zero or has more than one bit set, a data read returns 0xFFFFFFFF and a data write produces no downstream strobe.
- R7: Select bit k+1 addresses slot k, for k from 0 to NSLOT-1. During the request cycle cfg_sel_o is one-hot on that slot and cfg_we_o follows we_i. A read returns the lane-reversed cfg_rdata_i if cfg_present_i is 1 in the acknowledge cycle, and 0xFFFFFFFF otherwise.
- R8: A one-hot select that matches neither a slot nor the bridge's own header produces no strobe. A read then returns 0xFFFFFFFF.
- R9: Select bit 0 addresses the bridge's own header and never strobes downstream. In configuration-side order the header holds these words. Dword 0 is {DEV_ID, VEN_ID}. Dword 1 is 0x00000016. Dword 2 is CLASS_REV. Dword 3 is 0x00000008. Dword 18 is the mask register. Every other dword reads 0.
- R10: Header dwords 0 to 3 are read-only. The mask register at dword 18 resets to 3 << (2*BRIDGE_IDX) and is written per enabled byte lane.
- R11: An access in the window with address bit 23 clear is acknowledged. It strobes nothing, and a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request valid, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte address |
| size_i | input | 3 | Access size in bytes: 1, 2 or 4 |
| wdata_i | input | 32 | Write data, big-endian lanes |
| ack_o | output | 1 | Access acknowledge, one cycle after the request |
| rdata_o | output | 32 | Read data, valid with ack_o on reads |
| cfg_sel_o | output | NSLOT | One-hot downstream slot strobe |
| cfg_dev_o | output | 5 | Device number of the current select |
| cfg_fn_o | output | 3 | Function number |
| cfg_reg_o | output | 6 | Dword register index |
| cfg_be_o | output | 4 | Configuration-side byte enables |
| cfg_we_o | output | 1 | Downstream write strobe |
| cfg_wdata_o | output | 32 | Lane-reversed write data |
| cfg_rdata_i | input | 32 | Downstream read data, one cycle after the strobe |
| cfg_present_i | input | 1 | Downstream target present, one cycle after the strobe |

## Verification
The assertions assume the following about the inputs. Every access is a single-cycle req_i pulse. size_i holds 1, 2 or 4. A downstream target answers exactly one cycle after its strobe. The bench follows these rules. It raises each request for one cycle, waits for the acknowledge before the next request, and uses only legal sizes. Its slot model registers the read data and the present flag on the strobe edge.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;
  typedef enum logic [2:0] {
    K_IO   = 3'd0,
    K_CAR  = 3'd1,
    K_DEV  = 3'd2,
    K_SELF = 3'd3,
    K_BAD  = 3'd4
  } kind_e;

  function automatic logic [31:0] swap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/cfg_target_decode.sv
module cfg_target_decode
  import cfg_bridge_pkg::*;
#(
  parameter int NSLOT    = 4,
  parameter int SLOT_LSB = 1,
  parameter int SELF_BIT = 0,
  parameter int ID_LSB   = 11,
  parameter int ID_W     = 21
) (
  input  logic [31:0]      car_i,
  output kind_e            kind_o,
  output logic [NSLOT-1:0] sel_o,
  output logic [4:0]       dev_o
);
  logic [ID_W-1:0] idsel;
  logic            one_hot;

  assign idsel   = car_i[ID_LSB +: ID_W];
  assign one_hot = (idsel != '0) && ((idsel & (idsel - ID_W'(1))) == '0);

  for (genvar k = 0; k < NSLOT; k++) begin : g_sel
    assign sel_o[k] = idsel[SLOT_LSB + k];
  end

  always_comb begin
    dev_o = '0;
    for (int i = 0; i < ID_W; i++)
      if (idsel[i]) dev_o = 5'(i + ID_LSB);
  end

  always_comb begin
    if (car_i[0])            kind_o = K_BAD;
    else if (!one_hot)       kind_o = K_BAD;
    else if (idsel[SELF_BIT]) kind_o = K_SELF;
    else if (|sel_o)         kind_o = K_DEV;
    else                     kind_o = K_BAD;
  end
endmodule

// File: rtl/cfg_lane_enable.sv
module cfg_lane_enable (
  input  logic [2:0] size_i,
  input  logic [1:0] ofs_i,
  output logic [3:0] be_o
);
  always_comb begin
    unique case (size_i)
      3'd1:    be_o = 4'b0001 << ofs_i;
      3'd2:    be_o = ofs_i[1] ? 4'b1100 : 4'b0011;
      default: be_o = 4'b1111;
    endcase
  end
endmodule

// File: rtl/cfg_self_header.sv
module cfg_self_header #(
  parameter int          BRIDGE_IDX = 1,
  parameter logic [15:0] VEN_ID     = 16'hC0DE,
  parameter logic [15:0] DEV_ID     = 16'h0001,
  parameter logic [31:0] CLASS_REV  = 32'h0600_0003,
  parameter int          MASK_IDX   = 18
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [5:0]  reg_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o
);
  localparam logic [31:0] MASK_RST = 32'd3 << (2 * BRIDGE_IDX);

  logic [31:0] mask_q;

  for (genvar b = 0; b < 4; b++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mask_q[8*b +: 8] <= MASK_RST[8*b +: 8];
      else if (wr_i && reg_i == 6'(MASK_IDX) && be_i[b])
        mask_q[8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end

  always_comb begin
    unique case (reg_i)
      6'd0:          rdata_o = {DEV_ID, VEN_ID};
      6'd1:          rdata_o = 32'h0000_0016;
      6'd2:          rdata_o = CLASS_REV;
      6'd3:          rdata_o = 32'h0000_0008;
      6'(MASK_IDX):  rdata_o = mask_q;
      default:       rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cfg_bridge.sv
module cfg_bridge
  import cfg_bridge_pkg::*;
#(
  parameter int          BRIDGE_IDX = 1,
  parameter int          NSLOT      = 4,
  parameter int          SLOT_LSB   = 1,
  parameter int          SELF_BIT   = 0,
  parameter logic [15:0] VEN_ID     = 16'hC0DE,
  parameter logic [15:0] DEV_ID     = 16'h0001,
  parameter logic [31:0] CLASS_REV  = 32'h0600_0003
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [31:0]      addr_i,
  input  logic [2:0]       size_i,
  input  logic [31:0]      wdata_i,
  output logic             ack_o,
  output logic [31:0]      rdata_o,
  output logic [NSLOT-1:0] cfg_sel_o,
  output logic [4:0]       cfg_dev_o,
  output logic [2:0]       cfg_fn_o,
  output logic [5:0]       cfg_reg_o,
  output logic [3:0]       cfg_be_o,
  output logic             cfg_we_o,
  output logic [31:0]      cfg_wdata_o,
  input  logic [31:0]      cfg_rdata_i,
  input  logic             cfg_present_i
);
  localparam logic [7:0] WIN_TAG = 8'hF0 + 8'(2 * BRIDGE_IDX);

  logic [31:0]      car_q;
  kind_e            dec_kind, kind_now, kind_q;
  logic [NSLOT-1:0] dec_sel;
  logic             hit, cfg_req, self_wr;
  logic             ack_q, rd_q;
  logic [31:0]      hdr_rdata, hdr_q;

  cfg_target_decode #(
    .NSLOT(NSLOT), .SLOT_LSB(SLOT_LSB), .SELF_BIT(SELF_BIT)
  ) u_dec (
    .car_i(car_q), .kind_o(dec_kind), .sel_o(dec_sel), .dev_o(cfg_dev_o)
  );

  cfg_lane_enable u_lanes (
    .size_i(size_i), .ofs_i(addr_i[1:0]), .be_o(cfg_be_o)
  );

  cfg_self_header #(
    .BRIDGE_IDX(BRIDGE_IDX), .VEN_ID(VEN_ID), .DEV_ID(DEV_ID), .CLASS_REV(CLASS_REV)
  ) u_hdr (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(self_wr), .reg_i(cfg_reg_o),
    .be_i(cfg_be_o), .wdata_i(cfg_wdata_o), .rdata_o(hdr_rdata)
  );

  assign hit = req_i && (addr_i[31:24] == WIN_TAG);

  always_comb begin
    if (!addr_i[23])     kind_now = K_IO;
    else if (!addr_i[22]) kind_now = K_CAR;
    else                 kind_now = dec_kind;
  end

  assign cfg_req     = hit && (kind_now == K_DEV);
  assign self_wr     = hit && we_i && (kind_now == K_SELF);
  assign cfg_sel_o   = cfg_req ? dec_sel : '0;
  assign cfg_we_o    = cfg_req && we_i;
  assign cfg_wdata_o = swap32(wdata_i);
  assign cfg_reg_o   = car_q[7:2];
  assign cfg_fn_o    = car_q[10:8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      car_q  <= '0;
      ack_q  <= 1'b0;
      rd_q   <= 1'b0;
      kind_q <= K_IO;
      hdr_q  <= '0;
    end else begin
      if (hit && we_i && kind_now == K_CAR) car_q <= swap32(wdata_i);
      ack_q  <= hit;
      rd_q   <= hit && !we_i;
      kind_q <= kind_now;
      hdr_q  <= hdr_rdata;
    end
  end

  assign ack_o = ack_q;

  always_comb begin
    rdata_o = '0;
    if (rd_q) begin
      unique case (kind_q)
        K_CAR:   rdata_o = car_q;
        K_DEV:   rdata_o = cfg_present_i ? swap32(cfg_rdata_i) : '1;
        K_SELF:  rdata_o = swap32(hdr_q);
        K_BAD:   rdata_o = '1;
        default: rdata_o = '0;
      endcase
    end
  end

  // R7
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cfg_sel_o));

  // R5
  type1_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_sel_o != '0) |-> !car_q[0]);

  // R1
  ack_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> ack_o);

  // R1
  no_spurious_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(hit));

  // R3
  be_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_sel_o != '0) |-> (cfg_be_o != 4'b0000));

  // R9
  self_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    car_q[11 + SELF_BIT] |-> (cfg_sel_o == '0));
endmodule

// File: tb/cfg_bridge_bench.sv
`timescale 1ns/1ps
module cfg_bridge_bench;
  localparam logic [31:0] BASE = 32'hF200_0000;
  localparam logic [31:0] CA   = BASE | 32'h0080_0000;
  localparam logic [31:0] CD   = BASE | 32'h00C0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [2:0]  size = 3'd4;
  logic        ack;
  logic [31:0] rdata;
  logic [3:0]  sel;
  logic [4:0]  dev;
  logic [2:0]  fn;
  logic [5:0]  rg;
  logic [3:0]  be;
  logic        cwe;
  logic [31:0] cwdata;
  logic [31:0] crdata = '0;
  logic        cpresent = 1'b0;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [31:0] mem [4][64];

  // strobe fields seen in the request cycle
  logic [3:0] s_sel, s_be;
  logic [4:0] s_dev;
  logic [2:0] s_fn;
  logic [5:0] s_rg;
  logic       s_we;
  logic [31:0] s_wd;
  logic        r_ack;
  logic [31:0] r_data;

  always #2 clk = ~clk;

  cfg_bridge u_cfg_bridge (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata),
    .cfg_sel_o(sel), .cfg_dev_o(dev), .cfg_fn_o(fn), .cfg_reg_o(rg),
    .cfg_be_o(be), .cfg_we_o(cwe), .cfg_wdata_o(cwdata),
    .cfg_rdata_i(crdata), .cfg_present_i(cpresent)
  );

  // slot model: slots 0..2 present, slot 3 absent
  always @(posedge clk) begin
    if (sel != 4'b0) begin
      for (int s = 0; s < 4; s++) begin
        if (sel[s]) begin
          cpresent <= (s < 3);
          crdata   <= mem[s][rg];
          if (cwe && s < 3)
            for (int j = 0; j < 4; j++)
              if (be[j]) mem[s][rg][8*j +: 8] <= cwdata[8*j +: 8];
        end
      end
    end
  end

  function automatic logic [31:0] sw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] mkcar(input logic [20:0] id, input logic [2:0] f,
                                        input logic [5:0] r, input logic t);
    return {id, f, r, 1'b0, t};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic bus(input logic [31:0] a, input logic w, input logic [2:0] sz,
                     input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = sz; wdata = d;
    #1;
    s_sel = sel; s_be = be; s_dev = dev; s_fn = fn; s_rg = rg; s_we = cwe; s_wd = cwdata;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    r_ack = ack; r_data = rdata;
  endtask

  task automatic set_car(input logic [31:0] v);
    bus(CA, 1'b1, 3'd4, sw(v));
  endtask

  task automatic t_reset();
    chk("R1 reset ack", {31'b0, ack}, 32'd0);
    chk("R7 reset sel", {28'b0, sel}, 32'd0);
    bus(CA, 1'b0, 3'd4, 0);
    chk("R2 reset latch", r_data, 32'd0);
  endtask

  task automatic t_car();
    bus(CA, 1'b1, 3'd4, 32'h1122_3344);
    chk("R1 ack on write", {31'b0, r_ack}, 32'd1);
    bus(CA, 1'b0, 3'd4, 0);
    chk("R2 latch swapped", r_data, 32'h4433_2211);
    @(negedge clk);
    chk("R1 single-cycle ack", {31'b0, ack}, 32'd0);
  endtask

  task automatic t_dev_read();
    set_car(mkcar(21'b100, 3'd5, 6'd9, 1'b0));
    bus(CD, 1'b0, 3'd4, 0);
    chk("R7 sel slot1", {28'b0, s_sel}, 32'b0010);
    chk("R3 dev number", {27'b0, s_dev}, 32'd13);
    chk("R3 fn", {29'b0, s_fn}, 32'd5);
    chk("R3 reg", {26'b0, s_rg}, 32'd9);
    chk("R3 be size4", {28'b0, s_be}, 32'hF);
    chk("R4 read lanes", r_data, sw(mem[1][9]));
    set_car(mkcar(21'b10, 3'd0, 6'd1, 1'b0));
    bus(CD | 32'd3, 1'b0, 3'd1, 0);
    chk("R3 be size1 ofs3", {28'b0, s_be}, 32'b1000);
    chk("R4 byte lane3", {24'b0, r_data[7:0]}, {24'b0, mem[0][1][31:24]});
    bus(CD | 32'd2, 1'b0, 3'd2, 0);
    chk("R3 be size2 ofs2", {28'b0, s_be}, 32'b1100);
    bus(CD | 32'd1, 1'b0, 3'd1, 0);
    chk("R3 be size1 ofs1", {28'b0, s_be}, 32'b0010);
  endtask

  task automatic t_dev_write();
    logic [31:0] old, exp;
    set_car(mkcar(21'b1000, 3'd1, 6'd7, 1'b0));
    old = mem[2][7];
    bus(CD | 32'd2, 1'b1, 3'd2, 32'h0000_BEEF);
    chk("R7 write strobe", {31'b0, s_we}, 32'd1);
    chk("R4 write lanes", {16'b0, s_wd[31:16]}, 32'h0000_EFBE);
    exp = {8'hEF, 8'hBE, old[15:0]};
    bus(CD, 1'b0, 3'd4, 0);
    chk("R7 write readback", r_data, sw(exp));
  endtask

  task automatic t_type1();
    logic [31:0] old;
    old = mem[1][4];
    set_car(mkcar(21'b100, 3'd0, 6'd4, 1'b1));
    bus(CD, 1'b0, 3'd4, 0);
    chk("R5 type1 read", r_data, 32'hFFFF_FFFF);
    bus(CD, 1'b1, 3'd4, 32'h0BAD_0BAD);
    chk("R5 type1 no strobe", {28'b0, s_sel}, 32'd0);
    set_car(mkcar(21'b100, 3'd0, 6'd4, 1'b0));
    bus(CD, 1'b0, 3'd4, 0);
    chk("R5 type1 write dropped", r_data, sw(old));
  endtask

  task automatic t_bad_idsel();
    set_car(mkcar(21'b0, 3'd0, 6'd0, 1'b0));
    bus(CD, 1'b0, 3'd4, 0);
    chk("R6 zero select read", r_data, 32'hFFFF_FFFF);
    set_car(mkcar(21'b110, 3'd0, 6'd0, 1'b0));
    bus(CD, 1'b0, 3'd4, 0);
    chk("R6 multi select read", r_data, 32'hFFFF_FFFF);
    bus(CD, 1'b1, 3'd4, 32'h1234_5678);
    chk("R6 multi select no strobe", {28'b0, s_sel}, 32'd0);
  endtask

  task automatic t_missing();
    set_car(mkcar(21'b10000, 3'd0, 6'd2, 1'b0));
    bus(CD, 1'b0, 3'd4, 0);
    chk("R7 absent slot3 strobed", {28'b0, s_sel}, 32'b1000);
    chk("R7 absent slot3 read", r_data, 32'hFFFF_FFFF);
    set_car(mkcar(21'h10_0000, 3'd0, 6'd2, 1'b0));
    bus(CD, 1'b0, 3'd4, 0);
    chk("R8 no slot read", r_data, 32'hFFFF_FFFF);
    chk("R8 no slot no strobe", {28'b0, s_sel}, 32'd0);
    chk("R3 dev number top bit", {27'b0, s_dev}, 32'd31);
  endtask

  task automatic t_self();
    set_car(mkcar(21'b1, 3'd0, 6'd0, 1'b0));
    bus(CD, 1'b0, 3'd4, 0);
    chk("R9 self id", r_data, sw(32'h0001_C0DE));
    chk("R9 self no strobe", {28'b0, s_sel}, 32'd0);
    set_car(mkcar(21'b1, 3'd0, 6'd2, 1'b0));
    bus(CD, 1'b0, 3'd4, 0);
    chk("R9 self class", r_data, sw(32'h0600_0003));
    set_car(mkcar(21'b1, 3'd0, 6'd1, 1'b0));
    bus(CD, 1'b1, 3'd4, 32'hFFFF_FFFF);
    bus(CD, 1'b0, 3'd4, 0);
    chk("R10 command read-only", r_data, sw(32'h0000_0016));
    set_car(mkcar(21'b1, 3'd0, 6'd18, 1'b0));
    bus(CD, 1'b0, 3'd4, 0);
    chk("R10 mask reset", r_data, sw(32'h0000_000C));
    bus(CD | 32'd1, 1'b1, 3'd1, 32'h00A5_0000);
    bus(CD, 1'b0, 3'd4, 0);
    chk("R10 mask byte write", r_data, sw(32'h0000_A50C));
    set_car(mkcar(21'b1, 3'd0, 6'd5, 1'b0));
    bus(CD, 1'b0, 3'd4, 0);
    chk("R9 self unused dword", r_data, 32'd0);
  endtask

  task automatic t_window();
    bus(32'hF000_0000 | 32'h0080_0000, 1'b0, 3'd4, 0);
    chk("R1 outside window no ack", {31'b0, r_ack}, 32'd0);
    bus(BASE | 32'h0000_0100, 1'b0, 3'd4, 0);
    chk("R11 io ack", {31'b0, r_ack}, 32'd1);
    chk("R11 io read zero", r_data, 32'd0);
    chk("R11 io no strobe", {28'b0, s_sel}, 32'd0);
  endtask

  initial begin
    for (int s = 0; s < 4; s++)
      for (int r = 0; r < 64; r++)
        mem[s][r] = {8'(s), 8'(r), 16'hA55A};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_car();
    t_dev_read();
    t_dev_write();
    t_type1();
    t_bad_idsel();
    t_missing();
    t_self();
    t_window();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule